// File: doc/BRIEF.md
# Multi-Integration Companding Frame Sequencer

This block runs one image frame as a chain of integrations whose lengths grow geometrically, shortest first. Each integration starts with a one-cycle shutter reset and then holds the integrate control for a counted number of clocks. After that the block enters a readout sweep. During the sweep it steps a ramp code through a programmable window, advancing one code each time the readout reports a finished scan. A pixel that fires during a sweep is reported once. Its 10-bit word carries an inverted integration index as the exponent and the ramp code at the moment of firing as the mantissa. The shortest integration therefore lands in the highest segment, and the word set approximates a piecewise-linear log-like response.

Configuration is captured when the frame starts. The captured values are the number of integrations, the base length, the growth ratio, a saturation ceiling for the length, and the two ramp window limits. A bitmap records which pixels have already been reported in the current frame, so later firings of those pixels are dropped. Once the last sweep ends, the block walks the pixel array and emits a zero word for every pixel that never fired. The frame therefore leaves the block complete, with no reconstruction needed afterwards.

Top module: `lls_frame_seq`

## Requirements
- R1: A frame_start seen while idle captures the configuration and runs n integrations, where n is num_int clamped to the range 1..2^SEG_W. Before each integration, shutter_rst is high for exactly one cycle, and integrating is high in the cycles that follow; each integration is followed by a sweep with ramp_active high.
- R2: Integration 0 lasts B cycles, where B is base_time forced to at least 1 and capped at M, and M is max_time forced to at least 1. Integration k lasts min(L(k-1) × ratio, M) cycles, where L(k-1) is the length of integration k-1 and ratio is time_ratio forced to at least 1, so lengths never decrease.
- R3: In its first cycle a sweep shows ramp_code equal to win_lo. Each scan_done advances the code by one. The sweep ends on the scan_done that arrives while ramp_code is at or above win_hi, so a window with win_lo at or above win_hi is a single step at win_lo.
- R4: An event accepted during a sweep raises out_valid in the next cycle, together with its out_x and out_y. out_word[OUT_W-1:OUT_W-SEG_W] holds 2^SEG_W-1-k for integration k, and the lower OUT_W-SEG_W bits hold the ramp_code of the event cycle.
- R5: An event in the same cycle as scan_done takes the ramp code from before the advance, and an event on the final step of the window is accepted.
- R6: An event for a pixel already reported in the current frame produces no output, and so does an event outside a sweep.
- R7: After the last sweep, every pixel not yet reported is emitted once with word 0, in ascending address y*COLS+x. frame_done then pulses for one cycle.
- R8: A frame_start outside the idle state has no effect on the running frame.
- R9: While reset is held, every output is low or zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_start | input | 1 | Start a frame (used only when idle) |
| num_int | input | SEG_W+1 | Number of integrations requested |
| base_time | input | T_W | Length of the first integration in cycles |
| time_ratio | input | R_W | Length growth factor between integrations |
| max_time | input | T_W | Ceiling on any integration length |
| win_lo | input | OUT_W-SEG_W | First ramp code of each sweep |
| win_hi | input | OUT_W-SEG_W | Last ramp code of each sweep |
| scan_done | input | 1 | Readout finished scanning at the current code |
| evt_valid | input | 1 | Pixel fired event |
| evt_x | input | $clog2(COLS) | Column of the firing pixel |
| evt_y | input | $clog2(ROWS) | Row of the firing pixel |
| shutter_rst | output | 1 | Pixel reset pulse before each integration |
| integrating | output | 1 | Exposure in progress |
| ramp_active | output | 1 | Readout sweep in progress |
| ramp_code | output | OUT_W-SEG_W | Code for the ramp converter |
| out_valid | output | 1 | Pixel word valid |
| out_x | output | $clog2(COLS) | Column of the reported pixel |
| out_y | output | $clog2(ROWS) | Row of the reported pixel |
| out_word | output | OUT_W | Companded pixel value |
| frame_done | output | 1 | Frame complete pulse |

## Verification
A pixel event and a ramp advance can occur in the same cycle, and this is the hazard that most needs testing. The bench drives the last event of every ramp step together with scan_done, including on the final code of the window. It then checks that the reported mantissa is the code before the advance and that a firing on the last step is still reported. The bench also fires already-reported pixels and fires pixels during integration, in the same cycles where real events would be valid. Duplicate or misplaced words are caught through the per-pixel expected code table.

// File: rtl/lls_pkg.sv
// Shared types for the companding frame sequencer.
package lls_pkg;
    // Frame phases in the order one frame visits them.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RST   = 3'd1,
        ST_INT   = 3'd2,
        ST_SWEEP = 3'd3,
        ST_FLUSH = 3'd4,
        ST_DONE  = 3'd5
    } seq_state_t;
endpackage

// File: rtl/lls_int_timer.sv
// Integration length generator and exposure counter.
// Holds the length of the current integration. The length is clamped at
// frame start and multiplied by the ratio (saturating) between integrations.
// Counts one exposure of that length. Assumes cfg_load, step_next and arm
// are never high in the same cycle.
module lls_int_timer #(
    parameter int T_W = 16,
    parameter int R_W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_load,
    input  logic [T_W-1:0] base_in,
    input  logic [T_W-1:0] max_in,
    input  logic [R_W-1:0] ratio_in,
    input  logic           step_next,
    input  logic           arm,
    input  logic           run,
    output logic           expired
);
    localparam int P_W = T_W + R_W;

    logic [T_W-1:0] max_c, base_c, first_c, next_c;
    logic [T_W-1:0] max_q, cur_q, cnt_q;
    logic [R_W-1:0] ratio_q;
    logic [P_W-1:0] prod_c;

    // Clamp the raw configuration and form the next saturated length.
    always_comb begin
        max_c   = (max_in == '0) ? T_W'(1) : max_in;
        base_c  = (base_in == '0) ? T_W'(1) : base_in;
        first_c = (base_c > max_c) ? max_c : base_c;
        prod_c  = P_W'(cur_q) * P_W'(ratio_q);
        next_c  = (prod_c > P_W'(max_q)) ? max_q : prod_c[T_W-1:0];
    end

    // Keep the captured ceiling, ratio and current integration length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            max_q   <= T_W'(1);
            ratio_q <= R_W'(1);
            cur_q   <= T_W'(1);
        end else if (cfg_load) begin
            max_q   <= max_c;
            ratio_q <= (ratio_in == '0) ? R_W'(1) : ratio_in;
            cur_q   <= first_c;
        end else if (step_next) begin
            cur_q   <= next_c;
        end
    end

    // Count down the cycles of the running exposure.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (arm) begin
            cnt_q <= cur_q;
        end else if (run && cnt_q > T_W'(1)) begin
            cnt_q <= cnt_q - T_W'(1);
        end
    end

    assign expired = run && (cnt_q <= T_W'(1));

    assert_len_within_max_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q <= max_q);

    assert_len_nondecreasing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step_next |=> cur_q >= $past(cur_q));
endmodule

// File: rtl/lls_ramp_seq.sv
// Ramp code stepper for the readout sweep.
// Captures the window at frame start, loads the lower limit at the start of
// each sweep, and advances on scan_done until the upper limit is reached.
// Assumes start and active never occur in the same cycle.
module lls_ramp_seq #(
    parameter int M_W = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_load,
    input  logic [M_W-1:0] lo_in,
    input  logic [M_W-1:0] hi_in,
    input  logic           start,
    input  logic           active,
    input  logic           scan_done,
    output logic [M_W-1:0] code,
    output logic           sweep_end
);
    logic [M_W-1:0] lo_q, hi_q, code_q;
    logic           at_top;

    assign at_top    = (code_q >= hi_q);
    assign sweep_end = active && scan_done && at_top;
    assign code      = code_q;

    // Capture the window limits for the whole frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (cfg_load) begin
            lo_q <= lo_in;
            hi_q <= hi_in;
        end
    end

    // Step the ramp code through the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (start) begin
            code_q <= lo_q;
        end else if (active && scan_done && !at_top) begin
            code_q <= code_q + M_W'(1);
        end
    end

    assert_ramp_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> code_q >= lo_q);

    assert_ramp_ceiling_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && lo_q <= hi_q) |-> code_q <= hi_q);
endmodule

// File: rtl/lls_pixel_map.sv
// Per-frame record of reported pixels and end-of-frame walk.
// Accepts an event only during a sweep and only for a pixel not yet reported.
// During the flush it visits every address once and flags the ones never
// reported. Assumes sweeping and flush_run are never high together.
module lls_pixel_map #(
    parameter  int COLS = 8,
    parameter  int ROWS = 8,
    localparam int X_W  = $clog2(COLS),
    localparam int Y_W  = $clog2(ROWS),
    localparam int NPIX = COLS * ROWS,
    localparam int A_W  = $clog2(NPIX)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           evt_valid,
    input  logic [X_W-1:0] evt_x,
    input  logic [Y_W-1:0] evt_y,
    input  logic           sweeping,
    input  logic           flush_run,
    output logic           hit,
    output logic           flush_emit,
    output logic           flush_last,
    output logic [A_W-1:0] flush_idx
);
    logic [NPIX-1:0] read_q;
    logic [A_W-1:0]  idx_q, evt_addr;
    logic            in_range;

    // Decode the event address and decide whether the event is accepted.
    always_comb begin
        in_range   = (int'(evt_x) < COLS) && (int'(evt_y) < ROWS);
        evt_addr   = A_W'(int'(evt_y) * COLS + int'(evt_x));
        hit        = sweeping && evt_valid && in_range && !read_q[evt_addr];
        flush_emit = flush_run && !read_q[idx_q];
        flush_last = flush_run && (idx_q == A_W'(NPIX - 1));
    end

    assign flush_idx = idx_q;

    // Mark reported pixels and advance the flush walk.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            read_q <= '0;
            idx_q  <= '0;
        end else begin
            if (hit) begin
                read_q[evt_addr] <= 1'b1;
            end
            if (flush_run && !flush_last) begin
                idx_q <= idx_q + A_W'(1);
            end
        end
    end

    assert_marks_only_grow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> $countones(read_q) >= $past($countones(read_q)));

    assert_flush_apart_from_events_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && flush_emit));
endmodule

// File: rtl/lls_frame_seq.sv
// Companding frame sequencer, top level.
// Runs reset/integrate/sweep once per integration, then a flush that emits
// zero words, then a one-cycle done pulse. Packs each accepted event into an
// inverted-segment exponent plus ramp-code mantissa. All outputs come from
// registers. Assumes the readout raises at most one event per cycle.
module lls_frame_seq
    import lls_pkg::*;
#(
    parameter  int COLS   = 8,
    parameter  int ROWS   = 8,
    parameter  int OUT_W  = 10,
    parameter  int SEG_W  = 3,
    parameter  int T_W    = 16,
    parameter  int R_W    = 4,
    localparam int X_W    = $clog2(COLS),
    localparam int Y_W    = $clog2(ROWS),
    localparam int MANT_W = OUT_W - SEG_W,
    localparam int N_W    = SEG_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic [N_W-1:0]    num_int,
    input  logic [T_W-1:0]    base_time,
    input  logic [R_W-1:0]    time_ratio,
    input  logic [T_W-1:0]    max_time,
    input  logic [MANT_W-1:0] win_lo,
    input  logic [MANT_W-1:0] win_hi,
    input  logic              scan_done,
    input  logic              evt_valid,
    input  logic [X_W-1:0]    evt_x,
    input  logic [Y_W-1:0]    evt_y,
    output logic              shutter_rst,
    output logic              integrating,
    output logic              ramp_active,
    output logic [MANT_W-1:0] ramp_code,
    output logic              out_valid,
    output logic [X_W-1:0]    out_x,
    output logic [Y_W-1:0]    out_y,
    output logic [OUT_W-1:0]  out_word,
    output logic              frame_done
);
    localparam int NSEG = 1 << SEG_W;
    localparam int NPIX = COLS * ROWS;
    localparam int A_W  = $clog2(NPIX);

    seq_state_t        state_q, state_d;
    logic [SEG_W-1:0]  k_q;
    logic [N_W-1:0]    n_q, n_c;
    logic              cfg_load, arm, run, ramp_start, step_next, last_int;
    logic              expired, sweep_end, hit, flush_emit, flush_last;
    logic              sweeping, flush_run;
    logic [A_W-1:0]    flush_idx;
    logic [SEG_W-1:0]  seg_c;

    assign sweeping  = (state_q == ST_SWEEP);
    assign flush_run = (state_q == ST_FLUSH);
    assign last_int  = ({1'b0, k_q} == (n_q - N_W'(1)));
    assign seg_c     = SEG_W'(NSEG - 1) - k_q;

    // Clamp the requested integration count into 1..NSEG.
    always_comb begin
        if (num_int == '0) begin
            n_c = N_W'(1);
        end else if (num_int > N_W'(NSEG)) begin
            n_c = N_W'(NSEG);
        end else begin
            n_c = num_int;
        end
    end

    // Frame phase transitions and the one-cycle strobes for the sub-blocks.
    always_comb begin
        state_d    = state_q;
        cfg_load   = 1'b0;
        arm        = 1'b0;
        run        = 1'b0;
        ramp_start = 1'b0;
        step_next  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (frame_start) begin
                    cfg_load = 1'b1;
                    state_d  = ST_RST;
                end
            end
            ST_RST: begin
                arm     = 1'b1;
                state_d = ST_INT;
            end
            ST_INT: begin
                run = 1'b1;
                if (expired) begin
                    ramp_start = 1'b1;
                    state_d    = ST_SWEEP;
                end
            end
            ST_SWEEP: begin
                if (sweep_end) begin
                    if (last_int) begin
                        state_d = ST_FLUSH;
                    end else begin
                        step_next = 1'b1;
                        state_d   = ST_RST;
                    end
                end
            end
            ST_FLUSH: begin
                if (flush_last) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Phase register, integration index and captured integration count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            k_q     <= '0;
            n_q     <= N_W'(1);
        end else begin
            state_q <= state_d;
            if (cfg_load) begin
                k_q <= '0;
                n_q <= n_c;
            end else if (step_next) begin
                k_q <= k_q + SEG_W'(1);
            end
        end
    end

    // Register the pixel word for an accepted event or a flushed pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_x     <= '0;
            out_y     <= '0;
            out_word  <= '0;
        end else begin
            out_valid <= hit || flush_emit;
            if (hit) begin
                out_x    <= evt_x;
                out_y    <= evt_y;
                out_word <= {seg_c, ramp_code};
            end else if (flush_emit) begin
                out_x    <= X_W'(int'(flush_idx) % COLS);
                out_y    <= Y_W'(int'(flush_idx) / COLS);
                out_word <= '0;
            end
        end
    end

    assign shutter_rst = (state_q == ST_RST);
    assign integrating = (state_q == ST_INT);
    assign ramp_active = sweeping;
    assign frame_done  = (state_q == ST_DONE);

    lls_int_timer #(.T_W(T_W), .R_W(R_W)) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_load  (cfg_load),
        .base_in   (base_time),
        .max_in    (max_time),
        .ratio_in  (time_ratio),
        .step_next (step_next),
        .arm       (arm),
        .run       (run),
        .expired   (expired)
    );

    lls_ramp_seq #(.M_W(MANT_W)) ramp_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_load  (cfg_load),
        .lo_in     (win_lo),
        .hi_in     (win_hi),
        .start     (ramp_start),
        .active    (sweeping),
        .scan_done (scan_done),
        .code      (ramp_code),
        .sweep_end (sweep_end)
    );

    lls_pixel_map #(.COLS(COLS), .ROWS(ROWS)) map_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (cfg_load),
        .evt_valid  (evt_valid),
        .evt_x      (evt_x),
        .evt_y      (evt_y),
        .sweeping   (sweeping),
        .flush_run  (flush_run),
        .hit        (hit),
        .flush_emit (flush_emit),
        .flush_last (flush_last),
        .flush_idx  (flush_idx)
    );

    assert_one_phase_output_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({shutter_rst, integrating, ramp_active, frame_done}));

    assert_reset_then_integrate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        shutter_rst |=> integrating);

    assert_word_from_sweep_or_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(state_q) == ST_SWEEP || $past(state_q) == ST_FLUSH));

    assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && state_q == ST_INT) |=> !shutter_rst);
endmodule

// File: tb/lls_frame_seq_tb.sv
module lls_frame_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int COLS  = 4;
    localparam int ROWS  = 4;
    localparam int NPIX  = COLS * ROWS;
    localparam int SEG_W = 3;
    localparam int OUT_W = 10;
    localparam int MW    = OUT_W - SEG_W;
    localparam int NSEG  = 1 << SEG_W;
    localparam int T_W   = 12;
    localparam int R_W   = 4;
    localparam int XW    = $clog2(COLS);
    localparam int YW    = $clog2(ROWS);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 1'b0;
    logic [SEG_W:0] num_int = '0;
    logic [T_W-1:0] base_time = '0, max_time = '0;
    logic [R_W-1:0] time_ratio = '0;
    logic [MW-1:0] win_lo = '0, win_hi = '0;
    logic scan_done = 1'b0, evt_valid = 1'b0;
    logic [XW-1:0] evt_x = '0;
    logic [YW-1:0] evt_y = '0;
    logic shutter_rst, integrating, ramp_active, out_valid, frame_done;
    logic [MW-1:0] ramp_code;
    logic [XW-1:0] out_x;
    logic [YW-1:0] out_y;
    logic [OUT_W-1:0] out_word;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lls_frame_seq #(.COLS(COLS), .ROWS(ROWS), .OUT_W(OUT_W), .SEG_W(SEG_W),
                    .T_W(T_W), .R_W(R_W)) dut_i (.*);

    int checks = 0, errors = 0;
    int n_eff, lo_v, hi_v, steps;
    int exp_len [NSEG];
    int tgt_k [NPIX];
    int tgt_code [NPIX];
    bit seen [NPIX];
    bit inj_idle_evt, inj_busy_start;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_word(input int p);
        if (tgt_k[p] >= n_eff) return 0;
        return ((NSEG - 1 - tgt_k[p]) << MW) | tgt_code[p];
    endfunction

    // Set configuration, expected lengths and per-pixel firing targets.
    task automatic setup_frame(input int n, input int b, input int r, input int mx,
                               input int lo, input int hi, input int fr);
        int c, m, rr;
        num_int = (SEG_W + 1)'(n); base_time = T_W'(b); time_ratio = R_W'(r);
        max_time = T_W'(mx); win_lo = MW'(lo); win_hi = MW'(hi);
        n_eff = (n == 0) ? 1 : (n > NSEG ? NSEG : n);
        lo_v = lo; hi_v = hi;
        steps = (hi >= lo) ? hi - lo + 1 : 1;
        m = (mx == 0) ? 1 : mx;
        rr = (r == 0) ? 1 : r;
        c = (b == 0) ? 1 : b;
        if (c > m) c = m;
        for (int k = 0; k < NSEG; k++) begin
            exp_len[k] = c;
            c = (c * rr > m) ? m : c * rr;
        end
        for (int p = 0; p < NPIX; p++) begin
            tgt_k[p] = (p + fr) % (n_eff + 1);
            tgt_code[p] = lo + ((p * 3 + fr) % steps);
            seen[p] = 1'b0;
        end
    endtask

    task automatic drive_evt(input int p, input bit sd);
        evt_valid = 1'b1; evt_x = XW'(p % COLS); evt_y = YW'(p / COLS); scan_done = sd;
        @(negedge clk);
        evt_valid = 1'b0; scan_done = 1'b0;
    endtask

    // Readout model: fires each pixel at its target step, refires old ones.
    task automatic run_frame();
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        for (int k = 0; k < n_eff; k++) begin
            while (!ramp_active) begin
                if (inj_idle_evt && integrating) begin
                    inj_idle_evt = 1'b0;
                    for (int p = 0; p < NPIX; p++)
                        if (tgt_k[p] == 0) begin drive_evt(p, 1'b0); break; end
                end else if (inj_busy_start && integrating && k == 1) begin
                    inj_busy_start = 1'b0;
                    frame_start = 1'b1;
                    @(negedge clk);
                    frame_start = 1'b0;
                end else begin
                    @(negedge clk);
                end
            end
            for (int s = 0; s < steps; s++) begin
                int code, cnt, done_n;
                code = int'(ramp_code);
                if (k > 0)
                    for (int q = 0; q < NPIX; q++)
                        if (tgt_k[q] < k) begin drive_evt(q, 1'b0); break; end
                cnt = 0;
                for (int p = 0; p < NPIX; p++)
                    if (tgt_k[p] == k && tgt_code[p] == code) cnt++;
                done_n = 0;
                // R5: the last event of each step shares its cycle with scan_done
                for (int p = 0; p < NPIX; p++)
                    if (tgt_k[p] == k && tgt_code[p] == code) begin
                        done_n++;
                        drive_evt(p, done_n == cnt);
                    end
                if (cnt == 0) begin
                    scan_done = 1'b1;
                    @(negedge clk);
                    scan_done = 1'b0;
                end
            end
        end
        while (!frame_done) @(negedge clk);
        @(negedge clk);
    endtask

    // Output monitor.
    int mon_shut = 0, mon_sweeps = 0, run_len = 0, last_code = 0, last_flush = -1;
    bit prev_int = 1'b0, prev_ramp = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (shutter_rst) mon_shut++;
            if (integrating) run_len++;
            else if (prev_int) begin
                chk(run_len == exp_len[(mon_shut - 1) % NSEG], "R1 R2 integration length",
                    run_len, exp_len[(mon_shut - 1) % NSEG]);
                run_len = 0;
            end
            prev_int = integrating;
            if (ramp_active && !prev_ramp)
                chk(int'(ramp_code) == lo_v, "R3 first code", int'(ramp_code), lo_v);
            if (!ramp_active && prev_ramp) begin
                chk(last_code == ((hi_v >= lo_v) ? hi_v : lo_v), "R3 last code",
                    last_code, (hi_v >= lo_v) ? hi_v : lo_v);
                mon_sweeps++;
            end
            if (ramp_active) last_code = int'(ramp_code);
            prev_ramp = ramp_active;
            if (out_valid) begin
                int p;
                p = int'(out_y) * COLS + int'(out_x);
                chk(!seen[p], "R6 pixel reported twice", p, -1);
                seen[p] = 1'b1;
                if (tgt_k[p] >= n_eff) begin
                    chk(int'(out_word) == 0, "R7 flush word", int'(out_word), 0);
                    chk(mon_sweeps == n_eff && p > last_flush, "R7 flush order", p, last_flush + 1);
                    last_flush = p;
                end else begin
                    chk(int'(out_word) == exp_word(p), "R4 R5 pixel word", int'(out_word), exp_word(p));
                end
            end
            if (frame_done) begin
                int cnt;
                cnt = 0;
                for (int p = 0; p < NPIX; p++) if (seen[p]) cnt++;
                chk(cnt == NPIX, "R7 all pixels reported", cnt, NPIX);
                chk(mon_shut == n_eff, "R1 R8 integration count", mon_shut, n_eff);
                mon_shut = 0; mon_sweeps = 0; last_flush = -1;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        setup_frame(1, 1, 1, 1, 0, 0, 0);
        repeat (3) @(negedge clk);
        // R9: reset state
        chk({shutter_rst, integrating, ramp_active, out_valid, frame_done} == 5'b0,
            "R9 reset controls", int'({shutter_rst, integrating, ramp_active, out_valid, frame_done}), 0);
        chk(ramp_code == '0 && out_word == '0, "R9 reset data", int'(out_word), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R6: event during integration is ignored
        setup_frame(4, 3, 2, 20, 5, 12, 0);
        inj_idle_evt = 1'b1;
        run_frame();
        // R8: frame_start while busy; clamp of count to NSEG
        setup_frame(12, 1, 4, 100, 0, 3, 1);
        inj_busy_start = 1'b1;
        run_frame();
        // R2 R3: zero base, zero ratio, inverted window
        setup_frame(0, 0, 0, 50, 9, 3, 2);
        run_frame();
        // R2: base above ceiling
        setup_frame(3, 40, 3, 30, 120, 127, 3);
        run_frame();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule